// File: doc/BRIEF.md
# Dual Ramp Fault Timer

This block replaces the pair of capacitor timers found in a supply protection controller with two saturating up/down accumulators. One accumulator measures how long the start-up loop has been limiting power or current. The other measures how long the load has drawn more than the allowed current in normal operation. Each accumulator climbs by a large step on every clock while its run request is high and falls by a small step otherwise. The ratio of the two steps (41 : 8) gives the usual 5 : 1 asymmetry. A timeout is flagged as soon as either accumulator reaches a threshold shared by both.

A tie control makes both run requests feed the inrush accumulator alone, which gives the behaviour of a single shared capacitor. A retry cooldown sequencer takes over the inrush accumulator after a failed start. It ramps the accumulator up to the threshold and back down to zero a fixed number of times (64 by default) and then pulses a done output, after which the surrounding controller may attempt another start. A synchronous clear empties both accumulators and abandons any cooldown in progress.

Top module: `dual_ramp_timer`

## Requirements
- R1: After reset both accumulators read 0, timeout is 0, retry_busy is 0, retry_done is 0 and retry_cycles is 0.
- R2: While its charge request is active, an accumulator grows by 41 per clock and stops at full scale (2^ACC_W - 1, 65535 by default).
- R3: While its charge request is inactive, an accumulator shrinks by 8 per clock and stops at 0.
- R4: Outside retry with tied low, inr_run alone charges inr_acc and flt_run alone charges flt_acc; each request leaves the other accumulator draining.
- R5: Outside retry, timeout is 1 in the clock after either accumulator's new value is greater than or equal to thresh, and 0 when both are below it.
- R6: With tied high (outside retry), inr_run OR flt_run charges inr_acc, and flt_acc receives no charge and drains.
- R7: clr high at a clock edge sets both accumulators to 0, ends any retry cooldown (retry_busy 0, retry_cycles 0) and overrides all other inputs.
- R8: retry_start while idle sets retry_busy. During cooldown inr_run, flt_run and tied are ignored, inr_acc charges while below thresh and then drains to 0, flt_acc drains, and timeout is held at 0.
- R9: Each return of inr_acc to 0 in the drain phase completes one cycle and increments retry_cycles. On the 64th cycle retry_busy falls, retry_cycles returns to 0 and retry_done is 1 for exactly one clock.
- R10: retry_start while retry_busy is already 1 has no effect on the cooldown sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one accumulator step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both accumulators and the cooldown |
| tied | input | 1 | 1 = both run requests charge the inrush accumulator |
| retry_start | input | 1 | Begin the retry cooldown when idle |
| inr_run | input | 1 | Start-up loop is limiting power or current |
| flt_run | input | 1 | Normal operation with current above the limit |
| thresh | input | ACC_W | Timeout threshold shared by both accumulators |
| inr_acc | output | ACC_W | Inrush accumulator value |
| flt_acc | output | ACC_W | Fault accumulator value |
| timeout | output | 1 | Either accumulator has reached thresh (outside cooldown) |
| retry_busy | output | 1 | Cooldown sequence in progress |
| retry_done | output | 1 | One-clock pulse when the cooldown completes |
| retry_cycles | output | 6 | Completed cooldown cycles in the current sequence |

## Verification
The assertions assume that thresh is held steady while a cooldown is running and that rst_n is asserted for at least one edge before any stimulus. The step and floor properties also assume that thresh leaves room below full scale. The bench changes thresh only while retry_busy is low. It uses thresholds well below full scale for the cooldown runs, and it applies the full-scale threshold only during the saturation test. Run requests and retry_start are toggled freely during cooldown, because the block is required to ignore them there.

// File: rtl/dual_ramp_pkg.sv
package dual_ramp_pkg;

  typedef enum logic {
    PH_CHARGE = 1'b0,
    PH_DRAIN  = 1'b1
  } retry_phase_e;

  // One saturating accumulator step; arithmetic in 32 bits so ACC_W <= 31.
  function automatic logic [31:0] ramp_next(
    input logic [31:0] acc,
    input logic        up,
    input logic [31:0] full,
    input logic [31:0] up_step,
    input logic [31:0] dn_step
  );
    if (up)
      return (acc > full - up_step) ? full : acc + up_step;
    else
      return (acc < dn_step) ? 32'd0 : acc - dn_step;
  endfunction

  function automatic logic [31:0] full_scale(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

endpackage

// File: rtl/ramp_accum.sv
module ramp_accum
  import dual_ramp_pkg::*;
#(
  parameter int unsigned ACC_W   = 16,
  parameter int unsigned UP_STEP = 41,
  parameter int unsigned DN_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             charge,
  output logic [ACC_W-1:0] acc
);

  localparam logic [31:0] FULL32 = full_scale(ACC_W);
  localparam int unsigned PAD_W  = 32 - ACC_W;

  logic [31:0]      acc_wide;
  logic [ACC_W-1:0] acc_nxt;

  assign acc_wide = {{PAD_W{1'b0}}, acc};
  assign acc_nxt  = ACC_W'(ramp_next(acc_wide, charge, FULL32,
                                     32'(UP_STEP), 32'(DN_STEP)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else          acc <= acc_nxt;
  end

endmodule

// File: rtl/retry_sequencer.sv
module retry_sequencer
  import dual_ramp_pkg::*;
#(
  parameter int unsigned ACC_W  = 16,
  parameter int unsigned CYCLES = 64,
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] thresh,
  output logic             busy,
  output logic             charge_req,
  output logic             cycle_end,
  output logic             seq_last,
  output logic             done,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  retry_phase_e phase;
  logic         at_top;
  logic         at_floor;

  assign at_top     = (acc >= thresh);
  assign at_floor   = (acc == '0);
  assign charge_req = busy && (phase == PH_CHARGE) && !at_top;
  assign cycle_end  = busy && (phase == PH_DRAIN) && at_floor;
  assign seq_last   = cycle_end && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_CHARGE;
      count <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      busy  <= 1'b0;
      phase <= PH_CHARGE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= PH_CHARGE;
          count <= '0;
        end
      end else if (phase == PH_CHARGE) begin
        if (at_top) phase <= PH_DRAIN;
      end else if (cycle_end) begin
        phase <= PH_CHARGE;
        if (seq_last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          count <= '0;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dual_ramp_timer.sv
module dual_ramp_timer
  import dual_ramp_pkg::*;
#(
  parameter int unsigned ACC_W       = 16,
  parameter int unsigned UP_STEP     = 41,
  parameter int unsigned DN_STEP     = 8,
  parameter int unsigned RETRY_COUNT = 64,
  localparam int unsigned CNT_W = (RETRY_COUNT > 1) ? $clog2(RETRY_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tied,
  input  logic             retry_start,
  input  logic             inr_run,
  input  logic             flt_run,
  input  logic [ACC_W-1:0] thresh,
  output logic [ACC_W-1:0] inr_acc,
  output logic [ACC_W-1:0] flt_acc,
  output logic             timeout,
  output logic             retry_busy,
  output logic             retry_done,
  output logic [CNT_W-1:0] retry_cycles
);

  localparam int unsigned N_ACC = 2;
  localparam int unsigned IDX_INR = 0;
  localparam int unsigned IDX_FLT = 1;

  // Named internal events for the checker
  logic             inr_charge;
  logic             flt_charge;
  logic             seq_charge;
  logic             seq_cycle_end;
  logic             seq_last;
  logic [N_ACC-1:0] acc_hit;
  logic [N_ACC-1:0] chg_vec;
  logic [ACC_W-1:0] acc_q [N_ACC];

  assign inr_charge = retry_busy ? seq_charge : (inr_run | (tied & flt_run));
  assign flt_charge = ~retry_busy & ~tied & flt_run;
  assign chg_vec    = {flt_charge, inr_charge};

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    ramp_accum #(
      .ACC_W  (ACC_W),
      .UP_STEP(UP_STEP),
      .DN_STEP(DN_STEP)
    ) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .charge(chg_vec[g]),
      .acc   (acc_q[g])
    );
    assign acc_hit[g] = (acc_q[g] >= thresh);
  end

  assign inr_acc = acc_q[IDX_INR];
  assign flt_acc = acc_q[IDX_FLT];
  assign timeout = ~retry_busy & (|acc_hit);

  retry_sequencer #(
    .ACC_W (ACC_W),
    .CYCLES(RETRY_COUNT)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .start     (retry_start),
    .acc       (acc_q[IDX_INR]),
    .thresh    (thresh),
    .busy      (retry_busy),
    .charge_req(seq_charge),
    .cycle_end (seq_cycle_end),
    .seq_last  (seq_last),
    .done      (retry_done),
    .count     (retry_cycles)
  );

endmodule

// File: rtl/dual_ramp_timer_chk.sv
module dual_ramp_timer_chk #(
  parameter int unsigned ACC_W = 16,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             tied,
  input logic             retry_start,
  input logic [ACC_W-1:0] thresh,
  input logic [ACC_W-1:0] inr_acc,
  input logic [ACC_W-1:0] flt_acc,
  input logic             timeout,
  input logic             retry_busy,
  input logic             retry_done,
  input logic [CNT_W-1:0] retry_cycles,
  input logic             inr_charge,
  input logic             flt_charge,
  input logic             seq_cycle_end,
  input logic             seq_last
);

  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (inr_acc == '0) && (flt_acc == '0) && !retry_busy); // R7

  AST_INR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inr_charge) |=> (inr_acc > $past(inr_acc)) || (inr_acc == FULL)); // R2

  AST_INR_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inr_charge) |=> (inr_acc < $past(inr_acc)) || (inr_acc == '0)); // R3

  AST_FLT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !flt_charge) |=> (flt_acc < $past(flt_acc)) || (flt_acc == '0)); // R3

  AST_TIED_NO_FLT: assert property (@(posedge clk) disable iff (!rst_n)
    (tied && !clr) |=> (flt_acc <= $past(flt_acc))); // R6

  AST_TIMEOUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    retry_busy |-> !timeout); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_done |=> !retry_done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_done |-> !retry_busy && (retry_cycles == '0)); // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_last && !clr) |=> retry_done && !retry_busy); // R9

  AST_CYCLE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_cycle_end && !seq_last && !clr) |=> retry_cycles == $past(retry_cycles) + 1'b1); // R9

  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_busy && retry_start && !clr && !seq_cycle_end) |=> retry_busy && $stable(retry_cycles)); // R10

endmodule

bind dual_ramp_timer dual_ramp_timer_chk #(
  .ACC_W(ACC_W),
  .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .tied         (tied),
  .retry_start  (retry_start),
  .thresh       (thresh),
  .inr_acc      (inr_acc),
  .flt_acc      (flt_acc),
  .timeout      (timeout),
  .retry_busy   (retry_busy),
  .retry_done   (retry_done),
  .retry_cycles (retry_cycles),
  .inr_charge   (inr_charge),
  .flt_charge   (flt_charge),
  .seq_cycle_end(seq_cycle_end),
  .seq_last     (seq_last)
);

// File: tb/dual_ramp_timer_bench.sv
`timescale 1ns/1ps
module dual_ramp_timer_bench;

  localparam int ACC_W = 16;
  localparam int FULL  = 65535;
  localparam int UP    = 41;
  localparam int DN    = 8;
  localparam int NCYC  = 64;

  typedef struct {
    int    inr;
    int    flt;
    bit    to;
    bit    busy;
    bit    done;
    int    cnt;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, tied = 1'b0, retry_start = 1'b0, inr_run = 1'b0, flt_run = 1'b0;
  logic [ACC_W-1:0] thresh = 16'd200;
  logic [ACC_W-1:0] inr_acc, flt_acc;
  logic timeout, retry_busy, retry_done;
  logic [5:0] retry_cycles;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  exp_t q[$];

  // Reference state
  int m_inr = 0, m_flt = 0, m_cnt = 0;
  bit m_busy = 0, m_drain = 0, m_done = 0;

  always #2 clk = ~clk;

  dual_ramp_timer u_dual_ramp_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tied(tied), .retry_start(retry_start),
    .inr_run(inr_run), .flt_run(flt_run), .thresh(thresh),
    .inr_acc(inr_acc), .flt_acc(flt_acc), .timeout(timeout),
    .retry_busy(retry_busy), .retry_done(retry_done), .retry_cycles(retry_cycles)
  );

  function automatic int grow(int v);
    return (FULL - v < UP) ? FULL : v + UP;
  endfunction

  function automatic int shrink(int v);
    return (v <= DN) ? 0 : v - DN;
  endfunction

  // Advance the reference by one edge with the present inputs, queue the result.
  task automatic step(string tag);
    exp_t e;
    int thr;
    bit up_i, up_f;
    thr = int'(thresh);
    if (clr) begin
      m_inr = 0; m_flt = 0; m_busy = 0; m_drain = 0; m_cnt = 0; m_done = 0;
    end else begin
      if (m_busy) begin
        up_i = !m_drain && (m_inr < thr);
        up_f = 0;
      end else begin
        up_i = inr_run || (tied && flt_run);
        up_f = flt_run && !tied;
      end
      m_done = 0;
      if (!m_busy) begin
        if (retry_start) begin m_busy = 1; m_drain = 0; m_cnt = 0; end
      end else if (!m_drain) begin
        if (m_inr >= thr) m_drain = 1;
      end else if (m_inr == 0) begin
        m_drain = 0;
        if (m_cnt == NCYC - 1) begin m_busy = 0; m_done = 1; m_cnt = 0; end
        else m_cnt++;
      end
      m_inr = up_i ? grow(m_inr) : shrink(m_inr);
      m_flt = up_f ? grow(m_flt) : shrink(m_flt);
    end
    e.inr = m_inr; e.flt = m_flt; e.busy = m_busy; e.done = m_done; e.cnt = m_cnt;
    e.to = !m_busy && (m_inr >= thr || m_flt >= thr);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic steps(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Monitor: compare one queued item per edge, 1 ns after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (int'(inr_acc) != e.inr || int'(flt_acc) != e.flt || timeout != e.to ||
            retry_busy != e.busy || retry_done != e.done || int'(retry_cycles) != e.cnt) begin
          failures++;
          $display("FAIL %s: got inr=%0d flt=%0d to=%0b busy=%0b done=%0b cnt=%0d, expected inr=%0d flt=%0d to=%0b busy=%0b done=%0b cnt=%0d",
                   e.tag, inr_acc, flt_acc, timeout, retry_busy, retry_done, retry_cycles,
                   e.inr, e.flt, e.to, e.busy, e.done, e.cnt);
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state checked directly and through idle steps
    checks++;
    if (inr_acc != 0 || flt_acc != 0 || timeout || retry_busy || retry_done || retry_cycles != 0) begin
      failures++;
      $display("FAIL R1: got inr=%0d flt=%0d to=%0b busy=%0b, expected all zero",
               inr_acc, flt_acc, timeout, retry_busy);
    end
    steps(3, "R1 idle after reset");

    // R2/R5: inrush ramp crosses 200 after five steps
    inr_run = 1; steps(6, "R2 R5 inrush charge");
    inr_run = 0; steps(30, "R3 inrush drain to floor");

    // R4: fault accumulator alone, then both independently
    flt_run = 1; steps(6, "R4 fault charge");
    inr_run = 1; flt_run = 0; steps(3, "R4 inrush only");
    inr_run = 0; steps(40, "R3 both drain");

    // R6: tied mode, fault request charges the inrush accumulator
    tied = 1; flt_run = 1; steps(6, "R6 tied fault request");
    flt_run = 0; inr_run = 1; steps(2, "R6 tied inrush request");
    inr_run = 0; tied = 0; steps(40, "R6 drain after tie");

    // R2: saturation at full scale with the top threshold
    thresh = 16'hFFFF; inr_run = 1; steps(1605, "R2 saturate full scale");
    inr_run = 0; steps(3, "R3 drain from full");

    // R7: clear overrides running requests
    inr_run = 1; flt_run = 1; clr = 1; steps(2, "R7 clear overrides");
    clr = 0; inr_run = 0; flt_run = 0; thresh = 16'd200; steps(2, "R7 after clear");

    // R8/R9/R10: full cooldown from a timed-out state, requests toggled
    inr_run = 1; steps(6, "R5 timeout before retry");
    inr_run = 0; retry_start = 1; steps(1, "R8 retry start");
    retry_start = 0;
    for (int i = 0; i < 4000 && !m_done; i++) begin
      inr_run = (i % 3 == 0); flt_run = (i % 5 == 0); tied = (i % 7 == 0);
      retry_start = (i % 11 == 0);
      step((i % 11 == 0) ? "R10 restart ignored" : "R8 R9 cooldown");
    end
    inr_run = 0; flt_run = 0; tied = 0; retry_start = 0;
    steps(3, "R9 after done");

    // R7: clear aborts a cooldown in progress, small threshold
    thresh = 16'd90; retry_start = 1; steps(1, "R8 retry start small thr");
    retry_start = 0; steps(120, "R9 partial cooldown");
    clr = 1; steps(1, "R7 clear aborts retry");
    clr = 0; steps(5, "R7 idle after abort");

    // R8/R9: zero threshold cooldown
    thresh = 16'd0; retry_start = 1; steps(1, "R8 retry thr zero");
    retry_start = 0;
    for (int i = 0; i < 1000 && !m_done; i++) step("R9 cooldown thr zero");
    steps(2, "R9 idle thr zero");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    finish_run();
  end

endmodule